// File: doc/BRIEF.md
# Summary Interrupt Cause Aggregator

This block merges the pending lines of several interrupt banks (by default receive, transmit and miscellaneous) into one summary cause register and a single host interrupt line. Each bank drives one level that is high while any unmasked cause inside that bank is pending. The summary bit for that bank latches the level and holds it until the host reads the summary.

The host reads the summary through a read strobe. That read returns the bank bits and clears them in the same edge, so no separate acknowledge write is needed. A bank that is still pending at the read edge keeps its bit set.

A software mask register sits in front of the interrupt output, separate from any per-bank masks. It resets to all ones. The host blocks the whole line by writing all ones, and enables exactly the bank bits by writing their complement. A qualifier flags whether the value presented for reading is a usable cause: zero, or a value whose low byte is all ones, is marked as not valid.

Top module: `irq_cause_aggregator`

## Requirements
- R1: After reset, cause_o reads zero, irq_o is low, and every mask bit is set.
- R2: Bank i sets bit SRC_POS[i] of cause_o and no other bit. With the defaults, receive is bit 0, transmit is bit 1 and miscellaneous is bit 2.
- R3: A single cycle of a bank's pending level sets its summary bit after that clock edge, and the bit holds until a read.
- R4: A clock edge with cause_rd_i high clears every summary bit whose bank is not pending at that edge.
- R5: A bank that is pending at the read edge has its summary bit set again after that edge, so no event is lost.
- R6: irq_o is high exactly when some summary bit is set and the mask bit at the same position is 0. A mask write takes effect from the edge that stores it.
- R7: With the mask at all ones, irq_o stays low while the summary still collects pending banks.
- R8: Writing the complement of the bank bits (0xFFFF_FFF8 by default) enables all banks and no other position.
- R9: Clearing the mask bit of one bank only lets that bank raise irq_o. Other banks still set their summary bits but do not raise irq_o.
- R10: cause_valid_o is low when cause_o is zero or when cause_o[7:0] is all ones, and high otherwise.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_SRC | Pending level of each bank |
| cause_rd_i | input | 1 | Read strobe; clears the summary at the edge |
| cause_o | output | REG_W | Summary value presented for reading |
| cause_valid_o | output | 1 | Summary value is a usable cause |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | REG_W | Mask write data; a 1 blocks that position |
| irq_o | output | 1 | Host interrupt line |

## Verification
The bench builds two instances. One uses the defaults: three banks at bits 0 to 2 of a 32-bit register. It covers the bit assignment, clear-on-read, re-pending and the masking cases. The second uses eight banks placed on bits 0 to 7 of a 16-bit register. Only that layout can present a summary whose low byte is all ones, which brings the invalid-pattern branch of the qualifier within reach.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned POS_W = 8;
  typedef enum int unsigned { SRC_RX = 0, SRC_TX = 1, SRC_MISC = 2 } src_e;
  localparam int unsigned DEF_NUM_SRC = 3;
  localparam logic [DEF_NUM_SRC*POS_W-1:0] DEF_POS = {8'd2, 8'd1, 8'd0};
endpackage

// File: rtl/pc_summary.sv
module pc_summary #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] sum_o
);
  logic [NUM_SRC-1:0] sum_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sum_q[i] <= 1'b0;
      else if (clr_i) sum_q[i] <= pend_i[i];   // re-capture a bank still pending
      else            sum_q[i] <= sum_q[i] | pend_i[i];
    end

    assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[i] |=> sum_q[i]);
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_q[i] && !clr_i) |=> sum_q[i]);
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !pend_i[i]) |=> !sum_q[i]);
    assert_repend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && pend_i[i]) |=> sum_q[i]);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/pc_mask.sv
module pc_mask #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned REG_W   = 32,
  parameter logic [NUM_SRC*pc_pkg::POS_W-1:0] SRC_POS = pc_pkg::DEF_POS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  localparam int unsigned IDX_W = $clog2(REG_W);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      en_o[i] = ~mask_q[SRC_POS[i*pc_pkg::POS_W +: IDX_W]];
  end

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/pc_qualify.sv
module pc_qualify #(
  parameter int unsigned REG_W = 32
) (
  input  logic [REG_W-1:0] cause_i,
  output logic             valid_o
);
  localparam int unsigned LOW_W = (REG_W < 8) ? REG_W : 8;
  logic all_ones_low;

  assign all_ones_low = &cause_i[LOW_W-1:0];
  assign valid_o      = (|cause_i) && !all_ones_low;
endmodule

// File: rtl/irq_cause_aggregator.sv
module irq_cause_aggregator #(
  parameter int unsigned NUM_SRC = pc_pkg::DEF_NUM_SRC,
  parameter int unsigned REG_W   = 32,
  parameter logic [NUM_SRC*pc_pkg::POS_W-1:0] SRC_POS = pc_pkg::DEF_POS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               cause_rd_i,
  output logic [REG_W-1:0]   cause_o,
  output logic               cause_valid_o,
  input  logic               mask_we_i,
  input  logic [REG_W-1:0]   mask_wdata_i,
  output logic               irq_o
);
  localparam int unsigned IDX_W = $clog2(REG_W);

  logic [NUM_SRC-1:0] sum;
  logic [NUM_SRC-1:0] en;

  pc_summary #(.NUM_SRC(NUM_SRC)) u_summary (
    .clk_i (clk_i), .rst_ni (rst_ni), .pend_i (pend_i),
    .clr_i (cause_rd_i), .sum_o (sum)
  );

  pc_mask #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .SRC_POS(SRC_POS)) u_mask (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (mask_we_i),
    .wdata_i (mask_wdata_i), .en_o (en)
  );

  always_comb begin
    cause_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      cause_o[SRC_POS[i*pc_pkg::POS_W +: IDX_W]] = sum[i];
  end

  pc_qualify #(.REG_W(REG_W)) u_qual (.cause_i (cause_o), .valid_o (cause_valid_o));

  assign irq_o = |(sum & en);

  assert_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && (&mask_wdata_i)) |=> !irq_o);
  assert_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == '0) |-> !cause_valid_o);
endmodule

// File: tb/irq_cause_aggregator_tb.sv
module irq_cause_aggregator_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  pend = '0;
  logic        rd = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0, cause;
  logic        cvalid, irq;

  logic [7:0]  pend8 = '0;
  logic        rd8 = 1'b0;
  logic [15:0] cause8;
  logic        cvalid8, irq8;

  irq_cause_aggregator dut_i (
    .clk_i (clk), .rst_ni (rst_n), .pend_i (pend), .cause_rd_i (rd),
    .cause_o (cause), .cause_valid_o (cvalid), .mask_we_i (we),
    .mask_wdata_i (wdata), .irq_o (irq)
  );

  irq_cause_aggregator #(.NUM_SRC(8), .REG_W(16),
    .SRC_POS({8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0})) dut8_i (
    .clk_i (clk), .rst_ni (rst_n), .pend_i (pend8), .cause_rd_i (rd8),
    .cause_o (cause8), .cause_valid_o (cvalid8), .mask_we_i (1'b0),
    .mask_wdata_i (16'h0000), .irq_o (irq8)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); pend[idx] = 1'b1;
    @(negedge clk); pend = '0;
  endtask

  task automatic read_cause(output logic [31:0] v);
    @(negedge clk); v = cause; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic write_mask(input logic [31:0] m);
    @(negedge clk); we = 1'b1; wdata = m;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cause", cause, 0);
    check("R1 irq", irq, 0);
    check("R10 zero invalid", cvalid, 0);
  endtask

  task automatic t_mapping();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      pulse(i);
      check("R2 R3 bit position", cause, 32'(1) << i);
      check("R10 valid", cvalid, 1);
      check("R7 masked at reset", irq, 0);
      read_cause(v);
      check("R4 read value", v, 32'(1) << i);
      check("R4 cleared", cause, 0);
    end
  endtask

  task automatic t_hold();
    pulse(1);
    repeat (5) @(negedge clk);
    check("R3 held", cause, 32'h2);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    write_mask(32'hFFFF_FFF8);
    check("R8 irq after enable", irq, 1);
    read_cause(v);
    check("R6 irq drops after read", irq, 0);
    pulse(2);
    check("R8 misc raises", irq, 1);
    write_mask(32'hFFFF_FFFF);
    check("R7 all ones blocks", irq, 0);
    check("R7 summary kept", cause, 32'h4);
    write_mask(32'hFFFF_FFF8);
    check("R6 re-enable", irq, 1);
    read_cause(v);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    write_mask(32'hFFFF_FFFD);
    pulse(0);
    check("R9 rx collected", cause, 32'h1);
    check("R9 rx blocked", irq, 0);
    pulse(1);
    check("R9 tx raises", irq, 1);
    read_cause(v);
    check("R9 read both", v, 32'h3);
  endtask

  task automatic t_repend();
    logic [31:0] v;
    @(negedge clk); pend[2] = 1'b1;
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R5 still pending kept", cause, 32'h4);
    pend = '0;
    read_cause(v);
    check("R4 cleared after drop", cause, 0);
  endtask

  task automatic t_qualify();
    @(negedge clk); pend8 = 8'hFF;
    @(negedge clk); pend8 = '0;
    check("R2 eight bits", cause8, 16'h00FF);
    check("R10 low byte ones invalid", cvalid8, 0);
    @(negedge clk); rd8 = 1'b1; pend8 = 8'h7F;
    @(negedge clk); rd8 = 1'b0; pend8 = '0;
    check("R10 partial valid", cvalid8, 1);
    check("R5 recapture on read", cause8, 16'h007F);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_hold();
    t_enable();
    t_partial();
    t_repend();
    t_qualify();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule